// File: doc/BRIEF.md
# Privileged Control Register Access Unit

This unit serves the read and write operations that move values between the integer datapath and the processor's control and state registers. A request names an access class (unprivileged, privileged or hyperprivileged), a register index within that class, and two source operands. The unit decides from the current privilege bits and trap level whether the access is allowed. It then either returns the register value or commits the new value, or it reports one of two fault kinds.

The registers that belong to the current trap level (saved PC, saved next PC, saved state, trap type and the hyperprivileged saved state) are kept once per level. The unit also holds the tick and system-tick counters with their compare registers, the performance control and counter pair, the trap base, the pending-interrupt register and the two small unprivileged state registers. The processor-state, hyperprivileged-state and trap-level values are owned elsewhere. The unit reads them from its inputs, and a write to them only appears on the write strobe.

Every response comes one clock after its request. Each accepted write is also reported on a write strobe, together with its class, index and value.

Top module: `priv_ctl_access`

## Requirements
- R1: Unprivileged class (code 0) has no privilege check: index 0 is the condition-code register and index 1 is the address-space register, both 8 bits wide. Any other index in this class raises an illegal-instruction fault (code 2).
- R2: A privileged-class access (class code 1) raises a privileged-action fault (code 1) unless processor-state bit 2 or hyperprivileged-state bit 2 is set.
- R3: A hyperprivileged-class access (class code 2) raises a privileged-action fault unless hyperprivileged-state bit 2 is set. Processor-state bit 2 alone does not grant it. Hyper indices: 0 state, 1 saved state, 2 pending interrupts, 3 system-tick hyper compare.
- R4: A tick read (privileged index 4) or system-tick read (privileged index 11) lacking privilege faults only when bit 63 of that counter is set. A write to either counter lacking privilege always faults.
- R5: A read or write of the performance counter (privileged index 9) lacking privilege faults only when bit 0 of the performance control register (privileged index 8) is set.
- R6: The per-level registers (privileged indices 0..3, hyper index 1) raise an illegal-instruction fault when the trap level is 0. The privilege check comes first, so a denied access reports privileged-action even at trap level 0.
- R7: An unimplemented index, or class code 3, raises an illegal-instruction fault. This fault ranks below a privileged-action fault from the same class.
- R8: A write stores the XOR of the first source and the second operand. The second operand is either the second source register or the 13-bit immediate, sign-extended.
- R9: The per-level registers are stored once per trap level (1..MAX_TL). An access always uses the entry of the current trap level.
- R10: A faulting request issues no write strobe, returns zero read data and leaves every stored register unchanged.
- R11: The response comes one cycle after the request, and a following read sees the new value. Without a response, all outputs are zero. Read data is zero for writes.
- R12: Privileged index 6 (processor state), privileged index 7 (trap level) and hyper index 0 (hyper state) read the corresponding inputs, zero-extended. Writes to them appear only on the strobe.
- R13: Narrow registers keep only their low bits on a write: condition codes 8, address space 8, trap type 9.
- R14: After reset, every stored register reads zero and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_class | input | 2 | Access class: 0 unprivileged, 1 privileged, 2 hyperprivileged |
| req_index | input | IDX_W | Register index within the class |
| src_a | input | DATA_W | First source operand |
| src_b_reg | input | DATA_W | Second source register value |
| src_b_imm | input | 13 | Signed immediate second operand |
| use_imm | input | 1 | Select immediate as second operand |
| pstate_i | input | PSTATE_W | Current processor state (bit 2 = privileged) |
| hpstate_i | input | HPSTATE_W | Current hyperprivileged state (bit 2 = hyper) |
| tl_i | input | TL_W | Current trap level |
| rsp_valid | output | 1 | Response present |
| rd_data | output | DATA_W | Read result |
| fault | output | 2 | 0 none, 1 privileged-action, 2 illegal-instruction |
| wr_en | output | 1 | Accepted write strobe |
| wr_class | output | 2 | Class of the accepted write |
| wr_index | output | IDX_W | Index of the accepted write |
| wr_data | output | DATA_W | Value written |

## Verification
The assertions take it as given that the trap level on `tl_i` never exceeds `MAX_TL`, and the checker states this as its own property on the input. They also assume that the mode inputs are stable and meaningful whenever `req_valid` is high. The stimulus changes mode and trap level only at the falling edge, together with a request, and uses only trap levels 0 through 3 and 5. The reference model therefore never addresses a per-level entry that does not exist.

// File: rtl/priv_reg_pkg.sv
package priv_reg_pkg;

    localparam int SIMM_W   = 13;
    localparam int PRIV_BIT = 2;

    typedef enum logic [1:0] {
        CLS_USER  = 2'd0,
        CLS_PRIV  = 2'd1,
        CLS_HYPER = 2'd2,
        CLS_RSVD  = 2'd3
    } acc_class_e;

    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_PRIV_ACTION = 2'd1,
        FLT_ILLEGAL     = 2'd2
    } fault_e;

    typedef enum logic [4:0] {
        REG_NONE,
        REG_CCR,
        REG_ASI,
        REG_TPC,
        REG_TNPC,
        REG_TSTATE,
        REG_TT,
        REG_TICK,
        REG_TBA,
        REG_PSTATE,
        REG_TL,
        REG_PCR,
        REG_PIC,
        REG_TICK_CMP,
        REG_STICK,
        REG_STICK_CMP,
        REG_HPSTATE,
        REG_HTSTATE,
        REG_HINTP,
        REG_HSTICK_CMP
    } reg_id_e;

    typedef enum logic [1:0] {
        CHK_NONE,
        CHK_PRIV,
        CHK_HYPER
    } chk_kind_e;

    // which extra condition must hold before a missing privilege faults
    typedef enum logic [1:0] {
        GATE_ALWAYS,
        GATE_TICK_TOP,
        GATE_STICK_TOP,
        GATE_PCR_LOW
    } gate_e;

    typedef struct packed {
        reg_id_e   id;
        logic      impl;
        logic      tl_chk;
        chk_kind_e chk;
        gate_e     gate;
    } reg_desc_t;

    function automatic fault_e pick_fault(input logic priv_bad, input logic illegal);
        if (priv_bad)
            return FLT_PRIV_ACTION;
        else if (illegal)
            return FLT_ILLEGAL;
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/prc_decode.sv
module prc_decode
    import priv_reg_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  acc_class_e         cls,
    input  logic [IDX_W-1:0]   idx,
    input  logic               is_write,
    output reg_desc_t          desc
);

    int unsigned idx_n;
    assign idx_n = 32'(idx);

    always_comb begin
        desc.id     = REG_NONE;
        desc.impl   = 1'b0;
        desc.tl_chk = 1'b0;
        desc.chk    = CHK_NONE;
        desc.gate   = GATE_ALWAYS;
        unique case (cls)
            CLS_USER: begin
                case (idx_n)
                    0: begin desc.id = REG_CCR; desc.impl = 1'b1; end
                    1: begin desc.id = REG_ASI; desc.impl = 1'b1; end
                    default: ;
                endcase
            end
            CLS_PRIV: begin
                desc.chk = CHK_PRIV;
                case (idx_n)
                    0:  begin desc.id = REG_TPC;    desc.impl = 1'b1; desc.tl_chk = 1'b1; end
                    1:  begin desc.id = REG_TNPC;   desc.impl = 1'b1; desc.tl_chk = 1'b1; end
                    2:  begin desc.id = REG_TSTATE; desc.impl = 1'b1; desc.tl_chk = 1'b1; end
                    3:  begin desc.id = REG_TT;     desc.impl = 1'b1; desc.tl_chk = 1'b1; end
                    4:  begin
                        desc.id   = REG_TICK;
                        desc.impl = 1'b1;
                        desc.gate = is_write ? GATE_ALWAYS : GATE_TICK_TOP;
                    end
                    5:  begin desc.id = REG_TBA;    desc.impl = 1'b1; end
                    6:  begin desc.id = REG_PSTATE; desc.impl = 1'b1; end
                    7:  begin desc.id = REG_TL;     desc.impl = 1'b1; end
                    8:  begin desc.id = REG_PCR;    desc.impl = 1'b1; end
                    9:  begin
                        desc.id   = REG_PIC;
                        desc.impl = 1'b1;
                        desc.gate = GATE_PCR_LOW;
                    end
                    10: begin desc.id = REG_TICK_CMP; desc.impl = 1'b1; end
                    11: begin
                        desc.id   = REG_STICK;
                        desc.impl = 1'b1;
                        desc.gate = is_write ? GATE_ALWAYS : GATE_STICK_TOP;
                    end
                    12: begin desc.id = REG_STICK_CMP; desc.impl = 1'b1; end
                    default: ;
                endcase
            end
            CLS_HYPER: begin
                desc.chk = CHK_HYPER;
                case (idx_n)
                    0: begin desc.id = REG_HPSTATE;    desc.impl = 1'b1; end
                    1: begin desc.id = REG_HTSTATE;    desc.impl = 1'b1; desc.tl_chk = 1'b1; end
                    2: begin desc.id = REG_HINTP;      desc.impl = 1'b1; end
                    3: begin desc.id = REG_HSTICK_CMP; desc.impl = 1'b1; end
                    default: ;
                endcase
            end
            CLS_RSVD: ;
        endcase
    end

endmodule

// File: rtl/prc_access_check.sv
module prc_access_check
    import priv_reg_pkg::*;
(
    input  reg_desc_t desc,
    input  logic      priv_on,
    input  logic      hpriv_on,
    input  logic      tl_zero,
    input  logic      tick_top,
    input  logic      stick_top,
    input  logic      pcr_low,
    output fault_e    fault
);

    logic gate_hit;
    logic priv_bad;
    logic illegal;

    always_comb begin
        unique case (desc.gate)
            GATE_ALWAYS:    gate_hit = 1'b1;
            GATE_TICK_TOP:  gate_hit = tick_top;
            GATE_STICK_TOP: gate_hit = stick_top;
            GATE_PCR_LOW:   gate_hit = pcr_low;
        endcase

        case (desc.chk)
            CHK_PRIV:  priv_bad = gate_hit && !(priv_on || hpriv_on);
            CHK_HYPER: priv_bad = !hpriv_on;
            default:   priv_bad = 1'b0;
        endcase

        illegal = !desc.impl || (desc.tl_chk && tl_zero);
        fault   = pick_fault(priv_bad, illegal);
    end

endmodule

// File: rtl/prc_state_regs.sv
module prc_state_regs
    import priv_reg_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int MAX_TL    = 6,
    parameter int TL_W      = 3,
    parameter int PSTATE_W  = 13,
    parameter int HPSTATE_W = 12,
    parameter int CCR_W     = 8,
    parameter int ASI_W     = 8,
    parameter int TT_W      = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  reg_id_e              sel,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [TL_W-1:0]      tl_i,
    input  logic [PSTATE_W-1:0]  pstate_i,
    input  logic [HPSTATE_W-1:0] hpstate_i,
    output logic [DATA_W-1:0]    rdata,
    output logic                 tick_top,
    output logic                 stick_top,
    output logic                 pcr_low
);

    localparam int SLOT_W = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;

    logic [DATA_W-1:0] tpc_q     [MAX_TL];
    logic [DATA_W-1:0] tnpc_q    [MAX_TL];
    logic [DATA_W-1:0] tstate_q  [MAX_TL];
    logic [DATA_W-1:0] htstate_q [MAX_TL];
    logic [TT_W-1:0]   tt_q      [MAX_TL];

    logic [CCR_W-1:0]  ccr_q;
    logic [ASI_W-1:0]  asi_q;
    logic [DATA_W-1:0] tick_q, tick_cmp_q, stick_q, stick_cmp_q;
    logic [DATA_W-1:0] tba_q, pcr_q, pic_q, hintp_q, hstick_cmp_q;

    logic [SLOT_W-1:0] slot;

    // level n lives in slot n-1; out-of-range levels are excluded by the checker
    always_comb begin
        if (tl_i == '0)
            slot = '0;
        else if (32'(tl_i) > MAX_TL)
            slot = SLOT_W'(MAX_TL - 1);
        else
            slot = SLOT_W'(tl_i - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < MAX_TL; l++) begin
                tpc_q[l]     <= '0;
                tnpc_q[l]    <= '0;
                tstate_q[l]  <= '0;
                htstate_q[l] <= '0;
                tt_q[l]      <= '0;
            end
            ccr_q        <= '0;
            asi_q        <= '0;
            tick_q       <= '0;
            tick_cmp_q   <= '0;
            stick_q      <= '0;
            stick_cmp_q  <= '0;
            tba_q        <= '0;
            pcr_q        <= '0;
            pic_q        <= '0;
            hintp_q      <= '0;
            hstick_cmp_q <= '0;
        end else if (we) begin
            case (sel)
                REG_CCR:        ccr_q              <= wdata[CCR_W-1:0];
                REG_ASI:        asi_q              <= wdata[ASI_W-1:0];
                REG_TPC:        tpc_q[slot]        <= wdata;
                REG_TNPC:       tnpc_q[slot]       <= wdata;
                REG_TSTATE:     tstate_q[slot]     <= wdata;
                REG_TT:         tt_q[slot]         <= wdata[TT_W-1:0];
                REG_HTSTATE:    htstate_q[slot]    <= wdata;
                REG_TICK:       tick_q             <= wdata;
                REG_TICK_CMP:   tick_cmp_q         <= wdata;
                REG_STICK:      stick_q            <= wdata;
                REG_STICK_CMP:  stick_cmp_q        <= wdata;
                REG_TBA:        tba_q              <= wdata;
                REG_PCR:        pcr_q              <= wdata;
                REG_PIC:        pic_q              <= wdata;
                REG_HINTP:      hintp_q            <= wdata;
                REG_HSTICK_CMP: hstick_cmp_q       <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            REG_CCR:        rdata = DATA_W'(ccr_q);
            REG_ASI:        rdata = DATA_W'(asi_q);
            REG_TPC:        rdata = tpc_q[slot];
            REG_TNPC:       rdata = tnpc_q[slot];
            REG_TSTATE:     rdata = tstate_q[slot];
            REG_TT:         rdata = DATA_W'(tt_q[slot]);
            REG_HTSTATE:    rdata = htstate_q[slot];
            REG_TICK:       rdata = tick_q;
            REG_TICK_CMP:   rdata = tick_cmp_q;
            REG_STICK:      rdata = stick_q;
            REG_STICK_CMP:  rdata = stick_cmp_q;
            REG_TBA:        rdata = tba_q;
            REG_PCR:        rdata = pcr_q;
            REG_PIC:        rdata = pic_q;
            REG_HINTP:      rdata = hintp_q;
            REG_HSTICK_CMP: rdata = hstick_cmp_q;
            REG_PSTATE:     rdata = DATA_W'(pstate_i);
            REG_HPSTATE:    rdata = DATA_W'(hpstate_i);
            REG_TL:         rdata = DATA_W'(tl_i);
            default:        rdata = '0;
        endcase
    end

    assign tick_top  = tick_q[DATA_W-1];
    assign stick_top = stick_q[DATA_W-1];
    assign pcr_low   = pcr_q[0];

endmodule

// File: rtl/priv_ctl_access.sv
module priv_ctl_access
    import priv_reg_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int IDX_W     = 5,
    parameter int MAX_TL    = 6,
    parameter int PSTATE_W  = 13,
    parameter int HPSTATE_W = 12,
    parameter int CCR_W     = 8,
    parameter int ASI_W     = 8,
    parameter int TT_W      = 9,
    localparam int TL_W     = $clog2(MAX_TL + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_class,
    input  logic [IDX_W-1:0]     req_index,
    input  logic [DATA_W-1:0]    src_a,
    input  logic [DATA_W-1:0]    src_b_reg,
    input  logic [SIMM_W-1:0]    src_b_imm,
    input  logic                 use_imm,
    input  logic [PSTATE_W-1:0]  pstate_i,
    input  logic [HPSTATE_W-1:0] hpstate_i,
    input  logic [TL_W-1:0]      tl_i,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic [1:0]           fault,
    output logic                 wr_en,
    output logic [1:0]           wr_class,
    output logic [IDX_W-1:0]     wr_index,
    output logic [DATA_W-1:0]    wr_data
);

    reg_desc_t         desc;
    fault_e            fault_c;
    logic [DATA_W-1:0] imm_ext, operand, new_val, cur_val;
    logic              tick_top, stick_top, pcr_low;
    logic              grant, commit;

    assign imm_ext = {{(DATA_W - SIMM_W){src_b_imm[SIMM_W-1]}}, src_b_imm};
    assign operand = use_imm ? imm_ext : src_b_reg;
    assign new_val = src_a ^ operand;

    prc_decode #(.IDX_W(IDX_W)) u_decode (
        .cls      (acc_class_e'(req_class)),
        .idx      (req_index),
        .is_write (req_write),
        .desc     (desc)
    );

    prc_access_check u_check (
        .desc      (desc),
        .priv_on   (pstate_i[PRIV_BIT]),
        .hpriv_on  (hpstate_i[PRIV_BIT]),
        .tl_zero   (tl_i == '0),
        .tick_top  (tick_top),
        .stick_top (stick_top),
        .pcr_low   (pcr_low),
        .fault     (fault_c)
    );

    assign grant  = req_valid && (fault_c == FLT_NONE);
    assign commit = grant && req_write;

    prc_state_regs #(
        .DATA_W    (DATA_W),
        .MAX_TL    (MAX_TL),
        .TL_W      (TL_W),
        .PSTATE_W  (PSTATE_W),
        .HPSTATE_W (HPSTATE_W),
        .CCR_W     (CCR_W),
        .ASI_W     (ASI_W),
        .TT_W      (TT_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (commit),
        .sel       (desc.id),
        .wdata     (new_val),
        .tl_i      (tl_i),
        .pstate_i  (pstate_i),
        .hpstate_i (hpstate_i),
        .rdata     (cur_val),
        .tick_top  (tick_top),
        .stick_top (stick_top),
        .pcr_low   (pcr_low)
    );

    fault_e fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rd_data   <= '0;
            fault_q   <= FLT_NONE;
            wr_en     <= 1'b0;
            wr_class  <= '0;
            wr_index  <= '0;
            wr_data   <= '0;
        end else begin
            rsp_valid <= req_valid;
            fault_q   <= req_valid ? fault_c : FLT_NONE;
            rd_data   <= (grant && !req_write) ? cur_val : '0;
            wr_en     <= commit;
            wr_class  <= commit ? req_class : '0;
            wr_index  <= commit ? req_index : '0;
            wr_data   <= commit ? new_val : '0;
        end
    end

    assign fault = fault_q;

endmodule

// File: rtl/priv_ctl_access_chk.sv
module priv_ctl_access_chk
    import priv_reg_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int IDX_W     = 5,
    parameter int MAX_TL    = 6,
    parameter int PSTATE_W  = 13,
    parameter int HPSTATE_W = 12,
    localparam int TL_W     = $clog2(MAX_TL + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [1:0]           req_class,
    input logic [IDX_W-1:0]     req_index,
    input logic [DATA_W-1:0]    src_a,
    input logic [DATA_W-1:0]    src_b_reg,
    input logic [SIMM_W-1:0]    src_b_imm,
    input logic                 use_imm,
    input logic [PSTATE_W-1:0]  pstate_i,
    input logic [HPSTATE_W-1:0] hpstate_i,
    input logic [TL_W-1:0]      tl_i,
    input logic                 rsp_valid,
    input logic [DATA_W-1:0]    rd_data,
    input logic [1:0]           fault,
    input logic                 wr_en,
    input logic [1:0]           wr_class,
    input logic [IDX_W-1:0]     wr_index,
    input logic [DATA_W-1:0]    wr_data
);

    // R1
    user_open_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_class == 2'd0 && 32'(req_index) < 2 |=> fault == FLT_NONE);

    // R2
    priv_denied_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_class == 2'd1 && 32'(req_index) < 4
        && !pstate_i[PRIV_BIT] && !hpstate_i[PRIV_BIT] |=> fault == FLT_PRIV_ACTION);

    // R3
    hyper_denied_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_class == 2'd2 && !hpstate_i[PRIV_BIT] |=> fault == FLT_PRIV_ACTION);

    // R6
    tl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_class == 2'd1 && 32'(req_index) < 4
        && (pstate_i[PRIV_BIT] || hpstate_i[PRIV_BIT]) && tl_i == '0 |=> fault == FLT_ILLEGAL);

    // R8
    wr_reg_value_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && !use_imm |=> !wr_en || wr_data == $past(src_a ^ src_b_reg));

    // R8
    wr_imm_value_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && use_imm |=> !wr_en
        || wr_data == $past(src_a ^ {{(DATA_W - SIMM_W){src_b_imm[SIMM_W-1]}}, src_b_imm}));

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fault != FLT_NONE |-> !wr_en && rd_data == '0);

    // R11
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !wr_en && fault == FLT_NONE && rd_data == '0
        && wr_class == '0 && wr_index == '0);

    // R9
    tl_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(tl_i) <= MAX_TL);

endmodule

bind priv_ctl_access priv_ctl_access_chk #(
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .MAX_TL    (MAX_TL),
    .PSTATE_W  (PSTATE_W),
    .HPSTATE_W (HPSTATE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_class (req_class),
    .req_index (req_index),
    .src_a     (src_a),
    .src_b_reg (src_b_reg),
    .src_b_imm (src_b_imm),
    .use_imm   (use_imm),
    .pstate_i  (pstate_i),
    .hpstate_i (hpstate_i),
    .tl_i      (tl_i),
    .rsp_valid (rsp_valid),
    .rd_data   (rd_data),
    .fault     (fault),
    .wr_en     (wr_en),
    .wr_class  (wr_class),
    .wr_index  (wr_index),
    .wr_data   (wr_data)
);

// File: tb/priv_ctl_access_tb.sv
`timescale 1ns/1ps
module priv_ctl_access_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, use_imm = 1'b0;
    logic [1:0]  req_class = '0;
    logic [4:0]  req_index = '0;
    logic [63:0] src_a = '0, src_b_reg = '0;
    logic [12:0] src_b_imm = '0;
    logic [12:0] pstate_i = '0;
    logic [11:0] hpstate_i = '0;
    logic [2:0]  tl_i = '0;

    logic        rsp_valid, wr_en;
    logic [63:0] rd_data, wr_data;
    logic [1:0]  fault, wr_class;
    logic [4:0]  wr_index;

    always #2 clk = ~clk;

    priv_ctl_access u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_class(req_class), .req_index(req_index), .src_a(src_a),
        .src_b_reg(src_b_reg), .src_b_imm(src_b_imm), .use_imm(use_imm),
        .pstate_i(pstate_i), .hpstate_i(hpstate_i), .tl_i(tl_i),
        .rsp_valid(rsp_valid), .rd_data(rd_data), .fault(fault), .wr_en(wr_en),
        .wr_class(wr_class), .wr_index(wr_index), .wr_data(wr_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    logic [7:0]  m_ccr, m_asi;
    logic [63:0] m_tick, m_tcmp, m_stick, m_scmp, m_tba, m_pcr, m_pic, m_hintp, m_hscmp;
    logic [63:0] m_tpc [int];
    logic [63:0] m_tnpc [int];
    logic [63:0] m_tst [int];
    logic [63:0] m_htst [int];
    logic [8:0]  m_tt [int];

    // mode applied with the next request
    logic [12:0] nx_pst = '0;
    logic [11:0] nx_hpst = '0;
    logic [2:0]  nx_tl = '0;

    // expected response for the request driven at the previous falling edge
    string       e_tag = "R14";
    logic        e_valid = 0, e_wen = 0;
    logic [1:0]  e_flt = 0, e_wcls = 0;
    logic [4:0]  e_widx = 0;
    logic [63:0] e_rd = 0, e_wd = 0;

    localparam logic [12:0] PST_P = 13'h0004;
    localparam logic [11:0] HP_H  = 12'h004;

    task automatic model_reset();
        m_ccr = 0; m_asi = 0; m_tick = 0; m_tcmp = 0; m_stick = 0; m_scmp = 0;
        m_tba = 0; m_pcr = 0; m_pic = 0; m_hintp = 0; m_hscmp = 0;
        for (int l = 0; l <= 6; l++) begin
            m_tpc[l] = 0; m_tnpc[l] = 0; m_tst[l] = 0; m_htst[l] = 0; m_tt[l] = 0;
        end
    endtask

    task automatic compare();
        n_cmp++;
        if (rsp_valid !== e_valid || fault !== e_flt || rd_data !== e_rd || wr_en !== e_wen
            || wr_class !== e_wcls || wr_index !== e_widx || wr_data !== e_wd) begin
            n_bad++;
            $display("FAIL %s: got v=%0b f=%0d rd=%h we=%0b c=%0d i=%0d wd=%h exp v=%0b f=%0d rd=%h we=%0b c=%0d i=%0d wd=%h",
                     e_tag, rsp_valid, fault, rd_data, wr_en, wr_class, wr_index, wr_data,
                     e_valid, e_flt, e_rd, e_wen, e_wcls, e_widx, e_wd);
        end
    endtask

    task automatic mode(input logic [12:0] p, input logic [11:0] h, input int tl);
        nx_pst = p; nx_hpst = h; nx_tl = 3'(tl);
    endtask

    task automatic step(input string tag, input bit wr, input int cls, input int idx,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [12:0] imm, input bit ui);
        bit known, need_tl, deny, p, h;
        int t, flt;
        logic [63:0] r, v;
        @(negedge clk);
        compare();
        req_valid = 1; req_write = wr; req_class = 2'(cls); req_index = 5'(idx);
        src_a = a; src_b_reg = b; src_b_imm = imm; use_imm = ui;
        pstate_i = nx_pst; hpstate_i = nx_hpst; tl_i = nx_tl;
        t = int'(nx_tl);
        p = nx_pst[2] | nx_hpst[2];
        h = nx_hpst[2];
        v = a ^ (ui ? {{51{imm[12]}}, imm} : b);
        known = 0; need_tl = 0; deny = 0; r = 0;
        case (cls)
            0: case (idx)
                0: begin known = 1; r = 64'(m_ccr); end
                1: begin known = 1; r = 64'(m_asi); end
                default: ;
            endcase
            1: begin
                deny = !p;
                case (idx)
                    0:  begin known = 1; need_tl = 1; r = m_tpc[t]; end
                    1:  begin known = 1; need_tl = 1; r = m_tnpc[t]; end
                    2:  begin known = 1; need_tl = 1; r = m_tst[t]; end
                    3:  begin known = 1; need_tl = 1; r = 64'(m_tt[t]); end
                    4:  begin known = 1; r = m_tick; if (!wr && !m_tick[63]) deny = 0; end
                    5:  begin known = 1; r = m_tba; end
                    6:  begin known = 1; r = 64'(nx_pst); end
                    7:  begin known = 1; r = 64'(nx_tl); end
                    8:  begin known = 1; r = m_pcr; end
                    9:  begin known = 1; r = m_pic; if (!m_pcr[0]) deny = 0; end
                    10: begin known = 1; r = m_tcmp; end
                    11: begin known = 1; r = m_stick; if (!wr && !m_stick[63]) deny = 0; end
                    12: begin known = 1; r = m_scmp; end
                    default: ;
                endcase
            end
            2: begin
                deny = !h;
                case (idx)
                    0: begin known = 1; r = 64'(nx_hpst); end
                    1: begin known = 1; need_tl = 1; r = m_htst[t]; end
                    2: begin known = 1; r = m_hintp; end
                    3: begin known = 1; r = m_hscmp; end
                    default: ;
                endcase
            end
            default: ;
        endcase
        flt = deny ? 1 : ((!known || (need_tl && t == 0)) ? 2 : 0);
        if (flt == 0 && wr) begin
            case (cls)
                0: if (idx == 0) m_ccr = v[7:0]; else m_asi = v[7:0];
                1: case (idx)
                    0: m_tpc[t] = v;   1: m_tnpc[t] = v;  2: m_tst[t] = v;
                    3: m_tt[t] = v[8:0];
                    4: m_tick = v;     5: m_tba = v;      8: m_pcr = v;
                    9: m_pic = v;      10: m_tcmp = v;    11: m_stick = v;
                    12: m_scmp = v;
                    default: ;
                endcase
                2: case (idx)
                    1: m_htst[t] = v;  2: m_hintp = v;    3: m_hscmp = v;
                    default: ;
                endcase
                default: ;
            endcase
        end
        e_tag = tag; e_valid = 1; e_flt = 2'(flt);
        e_rd  = (flt == 0 && !wr) ? r : 64'd0;
        e_wen = (flt == 0 && wr);
        e_wcls = e_wen ? 2'(cls) : 2'd0;
        e_widx = e_wen ? 5'(idx) : 5'd0;
        e_wd   = e_wen ? v : 64'd0;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        compare();
        req_valid = 0; req_write = 0;
        e_tag = tag; e_valid = 0; e_flt = 0; e_rd = 0; e_wen = 0; e_wcls = 0; e_widx = 0; e_wd = 0;
    endtask

    task automatic rd(input string tag, input int cls, input int idx);
        step(tag, 0, cls, idx, 64'd0, 64'd0, 13'd0, 0);
    endtask

    task automatic wrr(input string tag, input int cls, input int idx, input logic [63:0] a, input logic [63:0] b);
        step(tag, 1, cls, idx, a, b, 13'd0, 0);
    endtask

    task automatic wri(input string tag, input int cls, input int idx, input logic [63:0] a, input logic [12:0] imm);
        step(tag, 1, cls, idx, a, 64'd0, imm, 1);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R14 reset state
        mode(13'h0, HP_H, 0);
        rd("R14", 1, 5); rd("R14", 0, 0); rd("R14", 1, 8); rd("R14", 2, 2);

        // R1 / R13 unprivileged registers with no privilege
        mode(13'h0, 12'h0, 0);
        wri("R1", 0, 0, 64'hFF00_0000_0000_00A5, 13'h00F);
        rd("R13", 0, 0);
        wrr("R1", 0, 1, 64'h1234, 64'h0F0F);
        rd("R1", 0, 1);
        rd("R1", 0, 3);

        // R2 privileged class
        rd("R2", 1, 5);
        mode(PST_P, 12'h0, 1);
        wrr("R2", 1, 5, 64'h0000_1234_5678_9ABC, 64'h00FF);
        rd("R11", 1, 5);
        mode(13'h0, 12'h0, 1);
        wrr("R10", 1, 5, 64'hDEAD, 64'hBEEF);
        mode(PST_P, 12'h0, 1);
        rd("R10", 1, 5);
        mode(13'h0, HP_H, 1);
        rd("R2", 1, 5);

        // R3 hyperprivileged class
        mode(PST_P, 12'h0, 1);
        rd("R3", 2, 2);
        wrr("R3", 2, 2, 64'h55, 64'h0);
        mode(13'h0, HP_H, 1);
        wrr("R3", 2, 2, 64'h77, 64'h1);
        rd("R3", 2, 2);
        rd("R7", 2, 9);

        // R4 tick and system tick gating
        mode(PST_P, 12'h0, 1);
        wri("R4", 1, 4, 64'h0, 13'h010);
        mode(13'h0, 12'h0, 1);
        rd("R4", 1, 4);
        wri("R4", 1, 4, 64'h0, 13'h001);
        mode(PST_P, 12'h0, 1);
        wrr("R4", 1, 4, 64'h8000_0000_0000_0000, 64'h5);
        mode(13'h0, 12'h0, 1);
        rd("R4", 1, 4);
        mode(PST_P, 12'h0, 1);
        rd("R4", 1, 4);
        wrr("R4", 1, 11, 64'h42, 64'h0);
        mode(13'h0, 12'h0, 1);
        rd("R4", 1, 11);
        mode(PST_P, 12'h0, 1);
        wrr("R4", 1, 11, 64'h8000_0000_0000_0042, 64'h0);
        mode(13'h0, 12'h0, 1);
        rd("R4", 1, 11);

        // R5 performance counter gating
        mode(PST_P, 12'h0, 1);
        wrr("R5", 1, 8, 64'h0, 64'h0);
        mode(13'h0, 12'h0, 1);
        wrr("R5", 1, 9, 64'h99, 64'h0);
        rd("R5", 1, 9);
        mode(PST_P, 12'h0, 1);
        wri("R5", 1, 8, 64'h0, 13'h001);
        mode(13'h0, 12'h0, 1);
        rd("R5", 1, 9);
        wrr("R5", 1, 9, 64'h11, 64'h0);
        mode(PST_P, 12'h0, 1);
        rd("R5", 1, 9);

        // R6 trap level zero checks and priority
        mode(PST_P, 12'h0, 0);
        rd("R6", 1, 0);
        wrr("R6", 1, 3, 64'h1, 64'h0);
        mode(13'h0, 12'h0, 0);
        rd("R6", 1, 2);
        mode(13'h0, HP_H, 0);
        rd("R6", 2, 1);

        // R9 / R13 per-level storage
        mode(PST_P, 12'h0, 1);
        wrr("R9", 1, 0, 64'hAAAA_0001, 64'h0);
        mode(PST_P, 12'h0, 2);
        wrr("R9", 1, 0, 64'hBBBB_0002, 64'h0);
        mode(PST_P, 12'h0, 1);
        rd("R9", 1, 0);
        mode(PST_P, 12'h0, 2);
        rd("R9", 1, 0);
        mode(PST_P, 12'h0, 3);
        wrr("R13", 1, 3, 64'hFFF, 64'h0);
        rd("R13", 1, 3);
        wrr("R9", 1, 1, 64'h3030, 64'h0);
        wrr("R9", 1, 2, 64'h4040, 64'h1);
        rd("R9", 1, 1);
        rd("R9", 1, 2);
        mode(13'h0, HP_H, 2);
        wrr("R9", 2, 1, 64'hCAFE, 64'h0);
        rd("R9", 2, 1);
        mode(13'h0, HP_H, 1);
        rd("R9", 2, 1);

        // R7 unimplemented indices
        mode(13'h0, 12'h0, 1);
        rd("R7", 1, 20);
        mode(PST_P, 12'h0, 1);
        rd("R7", 1, 20);
        rd("R7", 3, 0);
        rd("R7", 0, 31);

        // R12 externally owned registers
        mode(13'h1A5C, 12'h0, 5);
        rd("R12", 1, 6);
        rd("R12", 1, 7);
        wrr("R12", 1, 6, 64'h3, 64'h0);
        rd("R12", 1, 6);
        mode(13'h0, 12'h804, 5);
        rd("R12", 2, 0);
        wrr("R12", 2, 0, 64'h0, 64'h4);

        // R8 sign-extended immediate
        mode(PST_P, 12'h0, 1);
        wri("R8", 1, 5, 64'hF0F0, 13'h1000);
        rd("R8", 1, 5);
        wri("R8", 1, 10, 64'h1, 13'h0FFF);
        rd("R8", 1, 10);

        // R11 idle gap and response framing
        idle("R11");
        idle("R11");
        rd("R11", 1, 10);
        idle("R11");
        idle("R11");

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL R11: watchdog expired, got no end of run, expected end of run");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule